// File: doc/BRIEF.md
# Temperature Conversion Slice Scheduler

This block shares one temperature converter among three measurement channels: an on-die sensor (channel 0) and two remote-diode channels (channels 1 and 2). Each channel has its own enable input. The scheduler visits the enabled channels in turn, one conversion per slice, so all of them appear to run at once. Each conversion is a request/acknowledge exchange with an abstract converter. The converter returns a sample word when it acknowledges.

The on-die channel needs a single sample, and that sample is already the temperature code. A remote channel needs two samples taken in order: the first with the low diode bias current, the second with the high one. Its temperature code is the high sample minus the low sample, multiplied by a fixed gain and kept to the result width. Codes are two's complement with 4 fractional bits, so one step is 0.0625 degree.

Every finished conversion sets a sticky done flag for its channel. Software clears a flag by writing 1 to it. Each flag can also be routed to a shared interrupt line.

Top module: `tsense_slicer`

## Requirements
- R1: While reset is high, and in the cycle after it, conv_req, result_valid, done_flag and irq are all 0.
- R2: A request only ever starts on a channel whose chan_en bit was 1 when the channel was picked. With chan_en all 0 and no conversion in flight, conv_req stays 0.
- R3: Channels are served round-robin. After channel c finishes, the next channel served is the first enabled one in the order c+1, c+2, c+3 (mod 3). After reset the scan starts at channel 0.
- R4: Once conv_req is raised, it stays high until a cycle in which conv_ack is 1. Until then conv_sel and conv_bias hold their values. Each cycle with conv_req and conv_ack both high takes one sample from conv_data.
- R5: Channel 0 takes one sample with conv_bias 0, and result_temp equals that sample unchanged.
- R6: Channels 1 and 2 take two samples: the first with conv_bias 0 (low current), the second with conv_bias 1 (high current). result_temp is ((high - low) * GAIN) truncated to WIDTH bits, two's complement.
- R7: result_valid is high for exactly one cycle: the cycle after the final sample is accepted. In that cycle result_chan names the channel, and that channel's done_flag bit is already 1.
- R8: A done_flag bit stays 1 until a cycle in which its flag_clr bit is 1. A flag_clr bit clears only its own flag.
- R9: If a flag_clr bit and a completion on the same channel arrive in the same cycle, that flag ends up 1.
- R10: irq is 1 exactly when some done_flag bit is 1 and its irq_en bit is also 1.
- R11: Clearing a channel's enable bit in the middle of a remote conversion does not abort that conversion. It finishes and reports normally, and the channel is then skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 3 | Per-channel enable (bit 0 on-die, bits 1 and 2 remote) |
| irq_en | input | 3 | Per-channel interrupt routing |
| flag_clr | input | 3 | Write-1-to-clear pulses for done_flag |
| conv_req | output | 1 | Sample request to the converter |
| conv_sel | output | 2 | Channel being sampled |
| conv_bias | output | 1 | Diode bias: 0 low current, 1 high current |
| conv_ack | input | 1 | Converter accepts the request; conv_data is valid |
| conv_data | input | WIDTH | Sample word returned with conv_ack |
| result_valid | output | 1 | One-cycle strobe for a finished temperature code |
| result_chan | output | 2 | Channel of the finished code |
| result_temp | output | WIDTH | Temperature code, 4 fractional bits |
| done_flag | output | 3 | Sticky per-channel completion flags |
| irq | output | 1 | Interrupt from flags that are routed to it |

## Verification
The assertions assume the converter raises conv_ack only while conv_req is high, for one cycle per sample, with conv_data valid in that same cycle. They also assume reset is held for at least one clock edge. The bench's converter model waits until it sees a request before it acknowledges, and drops conv_ack after a single cycle. It changes chan_en and flag_clr only on the falling clock edge, so the checks on picking, bias order and flag stickiness see well-defined inputs.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int NCH = 3;

    typedef logic [1:0] chan_t;

    localparam chan_t CH_DIE  = 2'd0;
    localparam chan_t CH_RMTA = 2'd1;
    localparam chan_t CH_RMTB = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_t;

    function automatic logic is_remote(input chan_t ch);
        return ch != CH_DIE;
    endfunction

endpackage

// File: rtl/tsense_rr_pick.sv
module tsense_rr_pick
    import tsense_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [N-1:0] en,
    input  chan_t        last,
    output logic         any,
    output chan_t        next
);

    always_comb begin
        any  = 1'b0;
        next = last;
        // scan from farthest to nearest so the nearest enabled one wins
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (en[idx]) begin
                any  = 1'b1;
                next = chan_t'(idx);
            end
        end
    end

endmodule

// File: rtl/tsense_flag_bank.sv
module tsense_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= 1'b0;
            end else begin
                // a completion wins over a simultaneous clear
                flag[i] <= set[i] | (flag[i] & ~clr[i]);
            end
        end
    end

endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
    import tsense_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GAIN  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_any,
    input  chan_t            pick_ch,
    input  logic             conv_ack,
    input  logic [WIDTH-1:0] conv_data,
    output logic             conv_req,
    output chan_t            conv_sel,
    output logic             conv_bias,
    output chan_t            cur_ch,
    output logic             res_valid,
    output chan_t            res_chan,
    output logic [WIDTH-1:0] res_temp,
    output logic [NCH-1:0]   done_set
);

    localparam int GW = $clog2(GAIN + 1) + 1;
    localparam int PW = WIDTH + 1 + GW;

    seq_state_t       state;
    logic [WIDTH-1:0] lo_sample;
    logic             final_ack;

    logic signed [WIDTH:0]  delta;
    logic signed [PW-1:0]   scaled;

    assign delta  = (WIDTH+1)'($signed(conv_data)) - (WIDTH+1)'($signed(lo_sample));
    assign scaled = PW'(delta) * PW'(GAIN);

    assign final_ack = conv_ack &&
                       (((state == ST_FIRST) && !is_remote(cur_ch)) ||
                        (state == ST_SECOND));

    always_comb begin
        done_set = '0;
        if (final_ack) begin
            done_set[cur_ch] = 1'b1;
        end
    end

    assign conv_req  = (state != ST_IDLE);
    assign conv_sel  = cur_ch;
    assign conv_bias = (state == ST_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_ch    <= chan_t'(NCH - 1);
            lo_sample <= '0;
            res_valid <= 1'b0;
            res_chan  <= CH_DIE;
            res_temp  <= '0;
        end else begin
            res_valid <= final_ack;
            unique case (state)
                ST_IDLE: begin
                    if (pick_any) begin
                        cur_ch <= pick_ch;
                        state  <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (conv_ack) begin
                        if (is_remote(cur_ch)) begin
                            lo_sample <= conv_data;
                            state     <= ST_SECOND;
                        end else begin
                            res_temp <= conv_data;
                            res_chan <= cur_ch;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_SECOND: begin
                    if (conv_ack) begin
                        res_temp <= scaled[WIDTH-1:0];
                        res_chan <= cur_ch;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tsense_slicer.sv
module tsense_slicer
    import tsense_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GAIN  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       chan_en,
    input  logic [2:0]       irq_en,
    input  logic [2:0]       flag_clr,
    output logic             conv_req,
    output logic [1:0]       conv_sel,
    output logic             conv_bias,
    input  logic             conv_ack,
    input  logic [WIDTH-1:0] conv_data,
    output logic             result_valid,
    output logic [1:0]       result_chan,
    output logic [WIDTH-1:0] result_temp,
    output logic [2:0]       done_flag,
    output logic             irq
);

    logic           pick_any;
    chan_t          pick_ch;
    chan_t          cur_ch;
    logic [NCH-1:0] done_set;

    tsense_rr_pick #(.N(NCH)) u_pick (
        .en   (chan_en),
        .last (cur_ch),
        .any  (pick_any),
        .next (pick_ch)
    );

    tsense_ctrl #(.WIDTH(WIDTH), .GAIN(GAIN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pick_any  (pick_any),
        .pick_ch   (pick_ch),
        .conv_ack  (conv_ack),
        .conv_data (conv_data),
        .conv_req  (conv_req),
        .conv_sel  (conv_sel),
        .conv_bias (conv_bias),
        .cur_ch    (cur_ch),
        .res_valid (result_valid),
        .res_chan  (result_chan),
        .res_temp  (result_temp),
        .done_set  (done_set)
    );

    tsense_flag_bank #(.N(NCH)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (done_set),
        .clr  (flag_clr),
        .flag (done_flag)
    );

    assign irq = |(done_flag & irq_en);

endmodule

// File: rtl/tsense_slicer_chk.sv
module tsense_slicer_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] chan_en,
    input logic [2:0] flag_clr,
    input logic       conv_req,
    input logic       conv_ack,
    input logic [1:0] conv_sel,
    input logic       conv_bias,
    input logic       result_valid,
    input logic [1:0] result_chan,
    input logic [2:0] done_flag
);

    logic [2:0] en_q;
    logic [2:0] kept_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            kept_q <= '0;
        end else begin
            en_q   <= chan_en;
            kept_q <= done_flag & ~flag_clr;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!conv_req && !result_valid && done_flag == 3'b000));

    a_r2_pick_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req) |-> en_q[conv_sel]);

    a_r2_idle_when_none: assert property (@(posedge clk) disable iff (rst)
        (chan_en == 3'b000 && !conv_req) |=> !conv_req);

    a_r4_hold_request: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack) |=>
            (conv_req && $stable(conv_sel) && $stable(conv_bias)));

    a_r6_first_low_bias: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req) |-> !conv_bias);

    a_r6_high_only_remote: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_bias) |-> (conv_sel != 2'd0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    a_r7_flag_with_result: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> done_flag[result_chan]);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_flag & kept_q) == kept_q);

endmodule

bind tsense_slicer tsense_slicer_chk u_chk (.*);

// File: tb/tsense_slicer_tb.sv
module tsense_slicer_tb;

    localparam int W    = 16;
    localparam int GAIN = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   chan_en = '0;
    logic [2:0]   irq_en = '0;
    logic [2:0]   flag_clr = '0;
    logic         conv_ack = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         conv_req;
    logic [1:0]   conv_sel;
    logic         conv_bias;
    logic         result_valid;
    logic [1:0]   result_chan;
    logic [W-1:0] result_temp;
    logic [2:0]   done_flag;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int last_ch = 2;
    bit done_run = 0;

    always #2 clk = ~clk;

    tsense_slicer #(.WIDTH(W), .GAIN(GAIN)) u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .conv_req(conv_req), .conv_sel(conv_sel),
        .conv_bias(conv_bias), .conv_ack(conv_ack), .conv_data(conv_data),
        .result_valid(result_valid), .result_chan(result_chan),
        .result_temp(result_temp), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int next_ch(input logic [2:0] en, input int last);
        for (int k = 1; k <= 3; k++) begin
            if (en[(last + k) % 3]) return (last + k) % 3;
        end
        return -1;
    endfunction

    // one converter exchange; returns on the falling edge after the accepting edge
    task automatic serve(input int esel, input bit ebias, input logic [W-1:0] d,
                         input int dly, input logic [2:0] clr);
        int n = 0;
        while (!conv_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(conv_req == 1'b1, "R2", "request seen", int'(conv_req), 1);
        chk(int'(conv_sel) == esel, "R3", "conv_sel", int'(conv_sel), esel);
        chk(conv_bias == ebias, "R6", "conv_bias", int'(conv_bias), int'(ebias));
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(conv_req && int'(conv_sel) == esel && conv_bias == ebias,
                "R4", "hold while waiting", int'(conv_sel), esel);
        end
        conv_ack  = 1'b1;
        conv_data = d;
        flag_clr  = clr;
        @(negedge clk);
        conv_ack  = 1'b0;
        flag_clr  = '0;
    endtask

    task automatic convert(input int ch, input logic [W-1:0] lo, input logic [W-1:0] hi,
                           input int dly, input logic [2:0] clr_final,
                           input logic [2:0] en_after);
        int exp;
        if (ch == 0) begin
            serve(0, 1'b0, lo, dly, clr_final);
            exp = int'(lo);
        end else begin
            serve(ch, 1'b0, lo, dly, '0);
            serve(ch, 1'b1, hi, dly, clr_final);
            exp = ((int'($signed(hi)) - int'($signed(lo))) * GAIN) & 32'hFFFF;
        end
        chan_en = en_after;
        chk(result_valid == 1'b1, "R7", "result_valid", int'(result_valid), 1);
        chk(int'(result_chan) == ch, "R7", "result_chan", int'(result_chan), ch);
        chk(int'(result_temp) == exp, ch == 0 ? "R5" : "R6", "result_temp",
            int'(result_temp), exp);
        chk(done_flag[ch] == 1'b1, "R7", "flag with result", int'(done_flag), ch);
        last_ch = ch;
        @(negedge clk);
        chk(result_valid == 1'b0, "R7", "single pulse", int'(result_valid), 0);
    endtask

    task automatic quiet(input int cyc, input string req);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            chk(conv_req == 1'b0, req, "no request", int'(conv_req), 0);
        end
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic t_reset;
        chk(conv_req == 0 && result_valid == 0, "R1", "outputs in reset",
            int'(conv_req), 0);
        chk(done_flag == 3'b000 && irq == 0, "R1", "flags in reset",
            int'(done_flag), 0);
    endtask

    task automatic t_idle;
        chan_en = 3'b000;
        quiet(10, "R2");
    endtask

    task automatic t_single_channels;
        chan_en = 3'b001;
        convert(0, 16'h0190, '0, 0, '0, 3'b000);
        chk(irq == 1'b0, "R10", "irq masked", int'(irq), 0);
        chan_en = 3'b010;
        convert(1, 16'd1000, 16'd1100, 1, '0, 3'b000);
        chan_en = 3'b100;
        convert(2, 16'd2000, 16'd1990, 0, '0, 3'b000);
        quiet(4, "R2");
    endtask

    task automatic t_round_robin;
        logic [W-1:0] dvals [4];
        dvals[0] = 16'hFF70; dvals[1] = 16'd300; dvals[2] = 16'd500; dvals[3] = 16'd12;
        chan_en = 3'b111;
        for (int i = 0; i < 4; i++) begin
            int c;
            c = next_ch(3'b111, last_ch);
            convert(c, dvals[i], dvals[i] + 16'd37, (i == 1) ? 3 : 0, '0,
                    (i == 3) ? 3'b101 : 3'b111);
        end
        // from the last served channel, scanning skips disabled channel 1
        for (int i = 0; i < 2; i++) begin
            int c;
            c = next_ch(3'b101, last_ch);
            chk(c != 1, "R3", "model skips disabled", c, 0);
            convert(c, 16'd50 + 16'(i), 16'd90, 0, '0, (i == 1) ? 3'b000 : 3'b101);
        end
        quiet(4, "R2");
    endtask

    task automatic t_flags;
        chk(done_flag == 3'b111, "R8", "flags sticky", int'(done_flag), 7);
        irq_en = 3'b010;
        @(negedge clk);
        chk(irq == 1'b1, "R10", "irq routed", int'(irq), 1);
        clear_flags(3'b010);
        chk(done_flag == 3'b101, "R8", "clear one bit", int'(done_flag), 5);
        chk(irq == 1'b0, "R10", "irq after clear", int'(irq), 0);
        irq_en = 3'b100;
        @(negedge clk);
        chk(irq == 1'b1, "R10", "irq other channel", int'(irq), 1);
        clear_flags(3'b101);
        chk(done_flag == 3'b000, "R8", "clear rest", int'(done_flag), 0);
        chk(irq == 1'b0, "R10", "irq idle", int'(irq), 0);
        irq_en = 3'b000;
    endtask

    task automatic t_clear_collision;
        chan_en = 3'b010;
        convert(1, 16'd700, 16'd680, 0, 3'b010, 3'b000);
        chk(done_flag == 3'b010, "R9", "set beats clear", int'(done_flag), 2);
        clear_flags(3'b010);
        chk(done_flag == 3'b000, "R8", "later clear works", int'(done_flag), 0);
    endtask

    task automatic t_disable_mid;
        chan_en = 3'b100;
        serve(2, 1'b0, 16'd4000, 0, '0);
        chan_en = 3'b000;
        serve(2, 1'b1, 16'd4064, 0, '0);
        chk(result_valid == 1'b1 && int'(result_chan) == 2, "R11",
            "conversion finished", int'(result_valid), 1);
        chk(int'(result_temp) == 256, "R11", "result after disable",
            int'(result_temp), 256);
        quiet(10, "R11");
    endtask

    task automatic finish_run;
        if (!done_run) begin
            done_run = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_single_channels();
        t_round_robin();
        t_flags();
        t_clear_collision();
        t_disable_mid();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

endmodule